// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

The block gathers eight interrupt request lines into one interrupt output for a processor. Software reaches it through a two-address register port: address 0 is the command port and address 1 is the data port. Each has a write strobe, a read strobe and a shared 8-bit data path. Request edges are latched and held until they are served. A fixed priority picks the line to serve: line 0 is highest and line 7 is lowest. The output is raised only when that line outranks everything currently being serviced.

The processor answers the output with a one-cycle acknowledge pulse. One cycle later the block presents an 8-bit vector with a valid strobe. The vector is the programmed base plus the line number. After reset, software must run a three-word initialisation sequence before any interrupt can be raised. The same sequence selects explicit or automatic end-of-interrupt. If the request has vanished by acknowledge time, the lowest-priority vector is returned as a spurious answer.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset `irq_o` is low, a data-port read returns mask 0xFF, and a command-port read returns the request register, which is 0x00.
- R2: Until the third initialisation word has been written, `irq_o` stays low and the in-service register stays empty, even with an unmasked request pending.
- R3: A command write with bit 4 set starts initialisation. It clears the in-service register and selects request readback. The next three data writes are taken as the vector base, the cascade word and the mode word. After command 0x0E, command-port reads return the stored cascade word.
- R4: The vector for line n is {base[7:3], n}. For example, base 0x20 gives 0x20..0x27 and base 0x08 gives 0x08..0x0F.
- R5: Outside initialisation, a data write loads the mask (bit n = 1 masks line n), and a data read returns it. A masked pending line never raises `irq_o`. It does so once it is unmasked.
- R6: After command 0x0B, command reads return the in-service register. After command 0x0A, they return the request register.
- R7: Command 0x60+n clears in-service bit n and no other bit.
- R8: A rising request edge sets its request bit. The bit clears when the input falls or when the line is acknowledged. An input held high after its acknowledge does not re-raise `irq_o`.
- R9: The winner is the lowest-numbered unmasked pending line. `irq_o` is high only when the winner's number is lower than every in-service bit.
- R10: An acknowledge taken while `irq_o` is high clears the winner's request bit and, in normal mode, sets its in-service bit. `vec_valid_o` is high for exactly the one cycle after each acknowledge cycle.
- R11: With mode word bit 1 set (automatic end of interrupt), an acknowledge leaves the in-service register unchanged.
- R12: An acknowledge taken while `irq_o` is low returns {base[7:3], 7} and leaves the in-service register unchanged. This holds even when line 7 is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 1 | 0 selects the command port, 1 selects the data port |
| wr_i | input | 1 | Write strobe, one write per high cycle |
| rd_i | input | 1 | Read strobe; `rdata_o` is zero when it is low |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| req_i | input | 8 | Interrupt request lines |
| irq_o | output | 1 | Interrupt to the processor |
| ack_i | input | 1 | Interrupt acknowledge pulse |
| vec_valid_o | output | 1 | Vector valid, the cycle after an acknowledge |
| vec_o | output | 8 | Returned vector |

## Verification
A corrupted in-service register shows up in two ways. Interrupts are blocked that should nest, or lower lines break through. Both appear at `irq_o` in the cycle after the bad update, and the ISR readback after 0x0B exposes the register directly. A wrong request or mask register appears at `irq_o` one cycle after the request edge or mask write. A wrong base or winner appears in `vec_o` in the cycle after the acknowledge. An initialisation state that is out of step misfiles the data writes. That leaves the mask or base wrong at the next readback or vector.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned NL = 8;
  localparam int unsigned DW = 8;
  localparam int unsigned LW = $clog2(NL);

  localparam logic [DW-1:0] CMD_SEL_IRR  = 8'h0A;
  localparam logic [DW-1:0] CMD_SEL_ISR  = 8'h0B;
  localparam logic [DW-1:0] CMD_SEL_CASC = 8'h0E;
  localparam logic [DW-1-LW:0] CMD_EOI_TAG = 5'b01100; // 0x60..0x67

  typedef enum logic [2:0] {
    CFG_WAIT, CFG_BASE, CFG_CASC, CFG_MODE, CFG_RUN
  } cfg_state_e;

  typedef enum logic [1:0] {
    RD_IRR, RD_ISR, RD_CASC
  } rd_sel_e;
endpackage

// File: rtl/pic_regs.sv
module pic_regs
  import pic_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          addr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ready_o,
  output logic          init_o,
  output logic [DW-1:0] base_o,
  output logic [DW-1:0] casc_o,
  output logic          aeoi_o,
  output logic [NL-1:0] mask_o,
  output rd_sel_e       rd_sel_o,
  output logic          eoi_o,
  output logic [LW-1:0] eoi_line_o
);
  cfg_state_e st_q;
  logic cmd_wr, dat_wr;

  assign cmd_wr = wr_i & ~addr_i;
  assign dat_wr = wr_i & addr_i;
  assign init_o = cmd_wr & wdata_i[4];
  assign eoi_o  = cmd_wr & (wdata_i[DW-1:LW] == CMD_EOI_TAG);
  assign eoi_line_o = wdata_i[LW-1:0];
  assign ready_o = (st_q == CFG_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= CFG_WAIT;
      base_o   <= '0;
      casc_o   <= '0;
      aeoi_o   <= 1'b0;
      mask_o   <= '1;
      rd_sel_o <= RD_IRR;
    end else if (init_o) begin
      st_q     <= CFG_BASE;
      rd_sel_o <= RD_IRR;
    end else if (cmd_wr) begin
      if (wdata_i == CMD_SEL_IRR)       rd_sel_o <= RD_IRR;
      else if (wdata_i == CMD_SEL_ISR)  rd_sel_o <= RD_ISR;
      else if (wdata_i == CMD_SEL_CASC) rd_sel_o <= RD_CASC;
    end else if (dat_wr) begin
      unique case (st_q)
        CFG_BASE: begin
          base_o <= {wdata_i[DW-1:LW], {LW{1'b0}}};
          st_q   <= CFG_CASC;
        end
        CFG_CASC: begin
          casc_o <= wdata_i;
          st_q   <= CFG_MODE;
        end
        CFG_MODE: begin
          aeoi_o <= wdata_i[1];
          st_q   <= CFG_RUN;
        end
        default: mask_o <= wdata_i[NL-1:0];
      endcase
    end
  end
endmodule

// File: rtl/pic_irr.sv
module pic_irr
  import pic_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NL-1:0] req_i,
  input  logic [NL-1:0] clr_i,
  output logic [NL-1:0] irr_o
);
  logic [NL-1:0] req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= '0;
      irr_o <= '0;
    end else begin
      req_q <= req_i;
      // latch rising edges, drop when input falls or line is served
      irr_o <= (irr_o | (req_i & ~req_q)) & req_i & ~clr_i;
    end
  end
endmodule

// File: rtl/pic_arb.sv
module pic_arb
  import pic_pkg::*;
(
  input  logic          ready_i,
  input  logic [NL-1:0] irr_i,
  input  logic [NL-1:0] mask_i,
  input  logic [NL-1:0] isr_i,
  output logic          irq_o,
  output logic [LW-1:0] win_o
);
  logic [NL-1:0] pend;
  logic [LW:0]   win_rank, isr_rank;

  assign pend = irr_i & ~mask_i;

  always_comb begin
    win_rank = LW'(0) + (LW+1)'(NL);
    isr_rank = (LW+1)'(NL);
    for (int i = NL-1; i >= 0; i--) begin
      if (pend[i])  win_rank = (LW+1)'(i);
      if (isr_i[i]) isr_rank = (LW+1)'(i);
    end
  end

  assign win_o = win_rank[LW-1:0];
  assign irq_o = ready_i & (win_rank < isr_rank);
endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
  import pic_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [NL-1:0] req_i,
  output logic          irq_o,
  input  logic          ack_i,
  output logic          vec_valid_o,
  output logic [DW-1:0] vec_o
);
  logic          ready, init, aeoi, eoi;
  logic [DW-1:0] base, casc;
  logic [NL-1:0] mask, irr, isr_q, irr_clr, isr_set, eoi_oh;
  logic [LW-1:0] eoi_line, win;
  rd_sel_e       rd_sel;
  logic          take;

  pic_regs u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_i, .wdata_i,
    .ready_o(ready), .init_o(init), .base_o(base), .casc_o(casc),
    .aeoi_o(aeoi), .mask_o(mask), .rd_sel_o(rd_sel),
    .eoi_o(eoi), .eoi_line_o(eoi_line)
  );

  pic_irr u_irr (
    .clk_i, .rst_ni, .req_i, .clr_i(irr_clr), .irr_o(irr)
  );

  pic_arb u_arb (
    .ready_i(ready), .irr_i(irr), .mask_i(mask), .isr_i(isr_q),
    .irq_o(irq_o), .win_o(win)
  );

  assign take    = ack_i & irq_o;
  assign irr_clr = take ? (NL'(1) << win) : '0;
  assign isr_set = (take && !aeoi) ? (NL'(1) << win) : '0;
  assign eoi_oh  = eoi ? (NL'(1) << eoi_line) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q       <= '0;
      vec_valid_o <= 1'b0;
      vec_o       <= '0;
    end else begin
      isr_q       <= init ? '0 : ((isr_q & ~eoi_oh) | isr_set);
      vec_valid_o <= ack_i;
      if (ack_i)
        vec_o <= {base[DW-1:LW], take ? win : LW'(NL-1)};
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (addr_i) rdata_o = DW'(mask);
      else begin
        unique case (rd_sel)
          RD_ISR:  rdata_o = DW'(isr_q);
          RD_CASC: rdata_o = casc;
          default: rdata_o = DW'(irr);
        endcase
      end
    end
  end
endmodule

// File: rtl/pic8_ctrl_chk.sv
module pic8_ctrl_chk
  import pic_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ack_i,
  input logic          wr_i,
  input logic          irq_o,
  input logic          vec_valid_o,
  input logic [DW-1:0] vec_o,
  input logic          ready,
  input logic          aeoi,
  input logic [NL-1:0] irr,
  input logic [NL-1:0] mask,
  input logic [NL-1:0] isr_q
);
  AST_VALID_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> vec_valid_o); // R10
  AST_NO_VALID_WITHOUT_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> !vec_valid_o); // R10
  AST_UNINIT_ISR_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready |-> (isr_q == '0)); // R2
  AST_IRQ_NEEDS_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((irr & ~mask) != '0)); // R5
  AST_SPURIOUS_LINE7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_o) |=> (vec_o[LW-1:0] == LW'(NL-1))); // R12
  AST_AEOI_ISR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && aeoi && !wr_i) |=> $stable(isr_q)); // R11
endmodule

bind pic8_ctrl pic8_ctrl_chk u_chk (
  .clk_i, .rst_ni, .ack_i, .wr_i, .irq_o, .vec_valid_o, .vec_o,
  .ready, .aeoi, .irr, .mask, .isr_q
);

// File: tb/pic8_ctrl_tb.sv
module pic8_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       addr_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0, ack_i = 1'b0;
  logic [7:0] wdata_i = '0, req_i = '0;
  logic [7:0] rdata_o, vec_o;
  logic       irq_o, vec_valid_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  pic8_ctrl u_dut (.*);

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    @(negedge clk_i); addr_i = a; rd_i = 1'b1; #1 d = rdata_o; rd_i = 1'b0;
  endtask

  task automatic set_req(logic [7:0] v);
    @(negedge clk_i); req_i = v;
    @(negedge clk_i);
  endtask

  task automatic do_ack(string tag, logic [7:0] exp_vec);
    @(negedge clk_i); ack_i = 1'b1;
    @(negedge clk_i); ack_i = 1'b0;
    check({tag, " valid"}, {7'd0, vec_valid_o}, 8'h01);
    check({tag, " vector"}, vec_o, exp_vec);
    @(negedge clk_i);
    check({tag, " valid drop"}, {7'd0, vec_valid_o}, 8'h00);
  endtask

  task automatic init(logic [7:0] b, logic [7:0] c, logic [7:0] m);
    wr(0, 8'h11); wr(1, b); wr(1, c); wr(1, m);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 irq", {7'd0, irq_o}, 8'h00);
    rd(1, d); check("R1 mask", d, 8'hFF);
    rd(0, d); check("R1 irr", d, 8'h00);
  endtask

  task automatic t_uninit;
    wr(1, 8'h00);
    set_req(8'h08);
    check("R2 no irq before init", {7'd0, irq_o}, 8'h00);
    do_ack("R2 R12 uninit ack", 8'h07);
    set_req(8'h00);
  endtask

  task automatic t_init;
    logic [7:0] d;
    init(8'h20, 8'h04, 8'h01);
    wr(0, 8'h0E); rd(0, d); check("R3 cascade readback", d, 8'h04);
    wr(0, 8'h0A);
    rd(1, d); check("R5 mask kept", d, 8'h00);
  endtask

  task automatic t_basic;
    logic [7:0] d;
    set_req(8'h08);
    check("R8 irq on edge", {7'd0, irq_o}, 8'h01);
    rd(0, d); check("R6 irr read", d, 8'h08);
    do_ack("R4 R10 line3", 8'h23);
    wr(0, 8'h0B); rd(0, d); check("R10 isr set", d, 8'h08);
    check("R8 held no retrigger", {7'd0, irq_o}, 8'h00);
    wr(0, 8'h0A); rd(0, d); check("R10 irr cleared", d, 8'h00);
  endtask

  task automatic t_nest;
    logic [7:0] d;
    set_req(8'h28);
    check("R9 lower blocked", {7'd0, irq_o}, 8'h00);
    set_req(8'h2A);
    check("R9 higher nests", {7'd0, irq_o}, 8'h01);
    do_ack("R9 line1", 8'h21);
    wr(0, 8'h0B); rd(0, d); check("R9 isr nested", d, 8'h0A);
    wr(0, 8'h61); rd(0, d); check("R7 eoi line1 only", d, 8'h08);
    check("R9 still blocked", {7'd0, irq_o}, 8'h00);
    wr(0, 8'h63); rd(0, d); check("R7 eoi line3", d, 8'h00);
    check("R9 line5 now raises", {7'd0, irq_o}, 8'h01);
    do_ack("R9 line5", 8'h25);
    wr(0, 8'h65); wr(0, 8'h0A);
    set_req(8'h00);
  endtask

  task automatic t_mask;
    wr(1, 8'h04);
    set_req(8'h04);
    check("R5 masked no irq", {7'd0, irq_o}, 8'h00);
    wr(1, 8'h00);
    check("R5 unmask raises", {7'd0, irq_o}, 8'h01);
    do_ack("R5 line2", 8'h22);
    wr(0, 8'h62); set_req(8'h00);
  endtask

  task automatic t_spurious;
    logic [7:0] d;
    wr(1, 8'h80);
    set_req(8'h10);
    check("R12 irq up", {7'd0, irq_o}, 8'h01);
    set_req(8'h00);
    check("R8 fall clears", {7'd0, irq_o}, 8'h00);
    do_ack("R12 spurious", 8'h27);
    wr(0, 8'h0B); rd(0, d); check("R12 isr untouched", d, 8'h00);
  endtask

  task automatic t_aeoi;
    logic [7:0] d;
    init(8'h0B, 8'h02, 8'h03);
    rd(0, d); check("R3 irr select after init", d, 8'h00);
    wr(0, 8'h0E); rd(0, d); check("R3 cascade slave id", d, 8'h02);
    wr(0, 8'h0B);
    set_req(8'h40);
    do_ack("R4 R11 line6", 8'h0E);
    rd(0, d); check("R11 isr empty", d, 8'h00);
    check("R8 no retrigger", {7'd0, irq_o}, 8'h00);
    set_req(8'h70);
    do_ack("R9 pick line4", 8'h0C);
    set_req(8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_uninit();
    t_init();
    t_basic();
    t_nest();
    t_mask();
    t_spurious();
    t_aeoi();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule